// File: doc/BRIEF.md
# RAM-Hotspot Cartridge Bank Mapper

This block sits on the cartridge side of a 6507-style bus (13 address lines, 8 data lines, a read/write line and the PHI2 bus clock) and lets a cartridge reach up to 256 banks of 4 KB. The block sees every bus cycle, including cycles aimed at the console's own RAM in the zero-page range. When a qualified write lands on one chosen byte of that RAM, the byte on the data bus becomes the new bank number. Because the selecting byte lives in console RAM rather than in the cartridge window, no ROM location is lost to switching logic.

The mapper oversamples the bus with a fast system clock, finds the falling edge of PHI2 and takes the address and data from the last sample while PHI2 was high. A strobe is only produced when PHI2 stayed high with a stable address for a minimum number of samples, so short glitches cannot change the bank. The ROM address is built combinationally from the registered bank and the low 12 address lines, and the ROM enable is the inverse of A12. A mode input turns the mapper into a plain 4 KB cartridge.

Top module: `ram_hotspot_mapper`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the bank register clears to 0; after reset, `rom_addr[19:12]` is 0 until a qualified hotspot load.
- R2: `rom_en_n` is low exactly when `bus_addr[12]` is 1, with no clock delay.
- R3: With `plain_mode` low, `rom_addr` equals {bank[7:0], `bus_addr[11:0]`} combinationally; `rom_addr[11:0]` always equals `bus_addr[11:0]`.
- R4: A qualified write cycle (`bus_rw` = 0) to address 0x0080 loads the captured data byte into the bank; the new bank appears on `rom_addr[19:12]` after the third rising edge of `clk` following the first `clk` edge that samples PHI2 low, and not before.
- R5: With the default setting, a read cycle (`bus_rw` = 1) to the hotspot leaves the bank unchanged.
- R6: Cycles to any other address leave the bank unchanged, including 0x0081, the RAM mirror 0x0180 and the cartridge address 0x1080.
- R7: A PHI2 high phase counts only if it lasts at least MIN_HIGH (default 3) `clk` samples; a high phase of 1 or 2 samples loads nothing, one of exactly 3 samples loads.
- R8: The run of high samples must hold one address: a high phase whose last address differs from the one before it counts only the samples at the final address.
- R9: With `plain_mode` high, `rom_addr[19:12]` is 0, while hotspot writes still update the bank register, which shows again once `plain_mode` returns low.
- R10: The byte taken is the one present on the last `clk` sample with PHI2 high, so data that settles late in the phase is captured, and every value 0x00 to 0xFF is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Bus clock from the console; data valid while high |
| bus_addr | input | 13 | CPU address lines A12..A0 |
| bus_rw | input | 1 | CPU read/write line, 1 = read |
| bus_data | input | 8 | Data bus as seen by the cartridge |
| plain_mode | input | 1 | 1 = plain 4 KB cartridge, bank ignored |
| rom_addr | output | 20 | Address to the ROM array |
| rom_en_n | output | 1 | Active-low ROM chip/output enable |

## Verification
The enable and the address composition are combinational, so the bench compares them against its model on every clock, half a period after the inputs move. A bank load is due exactly three `clk` rising edges after the first edge that sees PHI2 low; each bus cycle task checks the old bank at the falling clock edge just before that third edge and the new bank just after it. Whether a cycle loads is worked out in the bench from the requirement rules (address, read/write, run length at one address, last data sample), never from the design.

// File: rtl/ram_hotspot_pkg.sv
package ram_hotspot_pkg;

  // Fixed geometry of the 6507-style bus
  localparam int BUS_AW = 13;
  localparam int BUS_DW = 8;
  // Cartridge window offset width; A12 is the select line just above it
  localparam int OFFS_W = 12;
  localparam int SEL_BIT = OFFS_W;
  // One bank number per data byte
  localparam int BANK_W = BUS_DW;
  localparam int ROM_AW = BANK_W + OFFS_W;

  // One oversampled view of the bus
  typedef struct packed {
    logic              phi2;
    logic              rw;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
  } bus_smp_t;

endpackage

// File: rtl/rhm_bus_sampler.sv
// Oversamples the asynchronous bus, finds the end of each PHI2 high phase
// and emits one strobe per qualified cycle with the last high-phase sample.
module rhm_bus_sampler
  import ram_hotspot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic [BUS_AW-1:0] addr,
  input  logic              rw,
  input  logic [BUS_DW-1:0] data,
  output logic              cyc_stb,
  output logic [BUS_AW-1:0] cyc_addr,
  output logic              cyc_rw,
  output logic [BUS_DW-1:0] cyc_data
);

  localparam int CNT_W = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_HIGH);

  bus_smp_t raw;
  bus_smp_t stg [SYNC_STAGES];
  bus_smp_t cur;
  bus_smp_t prv;
  logic [CNT_W-1:0] run_cnt;
  logic fall;

  assign raw = '{phi2: phi2, rw: rw, addr: addr, data: data};

  // Synchronizer chain: the whole bus vector travels with PHI2 so that
  // address and data stay aligned with the edge they belong to.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign cur = stg[SYNC_STAGES-1];

  // prv holds the sample one step older than cur; run_cnt is the number of
  // consecutive high samples, ending at prv, that carried one address.
  always_ff @(posedge clk) begin
    if (rst) begin
      prv     <= '0;
      run_cnt <= '0;
    end else begin
      prv <= cur;
      if (!cur.phi2) begin
        run_cnt <= '0;
      end else if (prv.phi2 && (cur.addr == prv.addr)) begin
        if (run_cnt != CNT_TOP) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= CNT_W'(1);
      end
    end
  end

  assign fall     = prv.phi2 & ~cur.phi2;
  assign cyc_stb  = fall && (run_cnt >= CNT_TOP) && !rst;
  assign cyc_addr = prv.addr;
  assign cyc_rw   = prv.rw;
  assign cyc_data = prv.data;

endmodule

// File: rtl/rhm_hotspot_match.sv
// Decides whether a qualified bus cycle selects a new bank.
module rhm_hotspot_match
  import ram_hotspot_pkg::*;
#(
  parameter logic [7:0] HOTSPOT      = 8'h80, // must lie in 0x80..0xFF
  parameter bit         FULL_DECODE  = 1'b1,  // 0: accept RAM mirrors too
  parameter bit         LOAD_ON_READ = 1'b0   // 1: reads load as well
) (
  input  logic              cyc_stb,
  input  logic [BUS_AW-1:0] cyc_addr,
  input  logic              cyc_rw,
  output logic              load
);

  logic addr_hit;
  logic dir_ok;

  generate
    if (FULL_DECODE) begin : g_full
      assign addr_hit = (cyc_addr == BUS_AW'(HOTSPOT));
    end else begin : g_mirror
      // Console RAM decodes on A12 low, A9 low and A7 high only
      assign addr_hit = !cyc_addr[SEL_BIT] && !cyc_addr[9] && cyc_addr[7]
                        && (cyc_addr[6:0] == HOTSPOT[6:0]);
    end

    if (LOAD_ON_READ) begin : g_any_dir
      assign dir_ok = 1'b1;
    end else begin : g_write_only
      assign dir_ok = !cyc_rw;
    end
  endgenerate

  assign load = cyc_stb & addr_hit & dir_ok;

endmodule

// File: rtl/rhm_bank_reg.sv
// Holds the current bank number.
module rhm_bank_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] bank
);

  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (load) bank <= din;
  end

endmodule

// File: rtl/rhm_rom_map.sv
// Combinational ROM address composition and enable; kept off any register
// so the ROM sees a new address as soon as the CPU presents one.
module rhm_rom_map
  import ram_hotspot_pkg::*;
(
  input  logic              plain_mode,
  input  logic [BANK_W-1:0] bank,
  input  logic [BUS_AW-1:0] addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_en_n
);

  logic [BANK_W-1:0] upper;

  always_comb begin
    upper = plain_mode ? '0 : bank;
    rom_addr = {upper, addr[OFFS_W-1:0]};
  end

  assign rom_en_n = ~addr[SEL_BIT];

endmodule

// File: rtl/ram_hotspot_mapper.sv
module ram_hotspot_mapper
  import ram_hotspot_pkg::*;
#(
  parameter logic [7:0] HOTSPOT      = 8'h80,
  parameter bit         FULL_DECODE  = 1'b1,
  parameter bit         LOAD_ON_READ = 1'b0,
  parameter int         SYNC_STAGES  = 2,
  parameter int         MIN_HIGH     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic [BUS_DW-1:0] bus_data,
  input  logic              plain_mode,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_en_n
);

  logic              cap_stb;
  logic [BUS_AW-1:0] cap_addr;
  logic              cap_rw;
  logic [BUS_DW-1:0] cap_data;
  logic              load_stb;
  logic [BANK_W-1:0] bank_q;

  rhm_bus_sampler #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_HIGH    (MIN_HIGH)
  ) i_sampler (
    .clk      (clk),
    .rst      (rst),
    .phi2     (phi2),
    .addr     (bus_addr),
    .rw       (bus_rw),
    .data     (bus_data),
    .cyc_stb  (cap_stb),
    .cyc_addr (cap_addr),
    .cyc_rw   (cap_rw),
    .cyc_data (cap_data)
  );

  rhm_hotspot_match #(
    .HOTSPOT      (HOTSPOT),
    .FULL_DECODE  (FULL_DECODE),
    .LOAD_ON_READ (LOAD_ON_READ)
  ) i_match (
    .cyc_stb  (cap_stb),
    .cyc_addr (cap_addr),
    .cyc_rw   (cap_rw),
    .load     (load_stb)
  );

  rhm_bank_reg #(
    .WIDTH (BANK_W)
  ) i_bank (
    .clk  (clk),
    .rst  (rst),
    .load (load_stb),
    .din  (cap_data),
    .bank (bank_q)
  );

  rhm_rom_map i_map (
    .plain_mode (plain_mode),
    .bank       (bank_q),
    .addr       (bus_addr),
    .rom_addr   (rom_addr),
    .rom_en_n   (rom_en_n)
  );

endmodule

// File: rtl/rhm_checker.sv
module rhm_checker
  import ram_hotspot_pkg::*;
#(
  parameter logic [7:0] HOTSPOT      = 8'h80,
  parameter bit         FULL_DECODE  = 1'b1,
  parameter bit         LOAD_ON_READ = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              plain_mode,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_en_n,
  input logic [BANK_W-1:0] bank_q,
  input logic              load_stb,
  input logic [BUS_AW-1:0] cap_addr,
  input logic              cap_rw,
  input logic [BUS_DW-1:0] cap_data
);

  AST_RESET_CLEARS_BANK: assert property (@(posedge clk)
    rst |=> (bank_q == '0)); // R1

  AST_ENABLE_OPPOSES_A12: assert property (@(posedge clk) disable iff (rst)
    rom_en_n != bus_addr[SEL_BIT]); // R2

  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    rom_addr[OFFS_W-1:0] == bus_addr[OFFS_W-1:0]); // R3

  AST_BANK_ON_UPPER: assert property (@(posedge clk) disable iff (rst)
    !plain_mode |-> (rom_addr[ROM_AW-1:OFFS_W] == bank_q)); // R3

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (bank_q == $past(cap_data))); // R4

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> $stable(bank_q)); // R4

  AST_READ_NEVER_LOADS: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (!cap_rw || LOAD_ON_READ)); // R5

  AST_LOAD_ONLY_AT_HOTSPOT: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (FULL_DECODE ? (cap_addr == BUS_AW'(HOTSPOT))
                              : (!cap_addr[SEL_BIT] && cap_addr[7]
                                 && cap_addr[6:0] == HOTSPOT[6:0]))); // R6

  AST_PLAIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    plain_mode |-> (rom_addr[ROM_AW-1:OFFS_W] == '0)); // R9

endmodule

bind ram_hotspot_mapper rhm_checker #(
  .HOTSPOT      (HOTSPOT),
  .FULL_DECODE  (FULL_DECODE),
  .LOAD_ON_READ (LOAD_ON_READ)
) i_rhm_checker (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .plain_mode (plain_mode),
  .rom_addr   (rom_addr),
  .rom_en_n   (rom_en_n),
  .bank_q     (bank_q),
  .load_stb   (load_stb),
  .cap_addr   (cap_addr),
  .cap_rw     (cap_rw),
  .cap_data   (cap_data)
);

// File: tb/test_ram_hotspot_mapper.sv
`timescale 1ns/1ps
module test_ram_hotspot_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b0;
  logic [12:0] bus_addr = 13'h1234;
  logic        bus_rw = 1'b1;
  logic [7:0]  bus_data = 8'h00;
  logic        plain_mode = 1'b0;
  logic [19:0] rom_addr;
  logic        rom_en_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_bank = 8'h00;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  ram_hotspot_mapper i_ram_hotspot_mapper (
    .clk        (clk),
    .rst        (rst),
    .phi2       (phi2),
    .bus_addr   (bus_addr),
    .bus_rw     (bus_rw),
    .bus_data   (bus_data),
    .plain_mode (plain_mode),
    .rom_addr   (rom_addr),
    .rom_en_n   (rom_en_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model compared on every clock, half a period after inputs move
  always @(negedge clk) begin
    if (run_chk && !rst) begin
      chk("R2 enable", {31'b0, rom_en_n}, {31'b0, ~bus_addr[12]});
      chk("R3 R9 address", {12'b0, rom_addr},
          {12'b0, (plain_mode ? 8'h00 : exp_bank), bus_addr[11:0]});
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    exp_bank = 8'h00;
  endtask

  // One PHI2 high phase: n1 samples of (a1,d1), then n2 samples of (a2,d2).
  task automatic bus_seq(input logic [12:0] a1, input logic [7:0] d1, input int n1,
                         input logic [12:0] a2, input logic [7:0] d2, input int n2,
                         input logic rw, input string tag);
    int run;
    logic [12:0] la;
    logic [7:0] ld;
    bit hit;
    logic [7:0] old_bank;
    logic [19:0] mid;
    if (n2 == 0) begin
      run = n1; la = a1; ld = d1;
    end else begin
      run = (a1 == a2) ? n1 + n2 : n2; la = a2; ld = d2;
    end
    hit = (la == 13'h0080) && !rw && (run >= 3);
    old_bank = exp_bank;
    @(posedge clk); #1;
    bus_addr = a1; bus_data = d1; bus_rw = rw; phi2 = 1'b1;
    repeat (n1) @(posedge clk);
    #1;
    if (n2 > 0) begin
      bus_addr = a2; bus_data = d2;
      repeat (n2) @(posedge clk);
      #1;
    end
    phi2 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mid = rom_addr;
    @(posedge clk); #1;
    if (hit) exp_bank = ld;
    if (!plain_mode) chk({tag, " R4 before third edge"}, {24'b0, mid[19:12]}, {24'b0, old_bank});
    bus_addr = 13'h1A5C; bus_rw = 1'b1;
    @(negedge clk);
    chk({tag, " bank after cycle"}, {24'b0, rom_addr[19:12]},
        {24'b0, (plain_mode ? 8'h00 : (hit ? ld : old_bank))});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    run_chk = 1'b1;
    @(negedge clk);
    chk("R1 reset bank", {12'b0, rom_addr}, {12'b0, 8'h00, 12'h234});
    chk("R2 enable with A12 high", {31'b0, rom_en_n}, 32'd0);

    bus_seq(13'h0080, 8'h5A, 6, 13'h0080, 8'h5A, 0, 1'b0, "R4 write");
    bus_seq(13'h0080, 8'h11, 6, 13'h0080, 8'h11, 0, 1'b1, "R5 read");
    bus_seq(13'h0081, 8'h22, 6, 13'h0081, 8'h22, 0, 1'b0, "R6 0x81");
    bus_seq(13'h0180, 8'h33, 6, 13'h0180, 8'h33, 0, 1'b0, "R6 mirror");
    bus_seq(13'h1080, 8'h44, 6, 13'h1080, 8'h44, 0, 1'b0, "R6 rom space");
    bus_seq(13'h0080, 8'h66, 1, 13'h0080, 8'h66, 0, 1'b0, "R7 one sample");
    bus_seq(13'h0080, 8'h66, 2, 13'h0080, 8'h66, 0, 1'b0, "R7 two samples");
    bus_seq(13'h0080, 8'h67, 3, 13'h0080, 8'h67, 0, 1'b0, "R7 three samples");
    bus_seq(13'h0090, 8'h70, 4, 13'h0080, 8'h70, 1, 1'b0, "R8 short tail");
    bus_seq(13'h0090, 8'h71, 4, 13'h0080, 8'h71, 3, 1'b0, "R8 full tail");
    bus_seq(13'h0080, 8'h33, 3, 13'h0080, 8'hC4, 2, 1'b0, "R10 late data");
    bus_seq(13'h0080, 8'hFF, 5, 13'h0080, 8'hFF, 0, 1'b0, "R10 max bank");
    bus_seq(13'h0080, 8'h00, 5, 13'h0080, 8'h00, 0, 1'b0, "R10 zero bank");

    // R2: RAM-space address keeps the ROM disabled
    @(posedge clk); #1; bus_addr = 13'h00F0;
    @(negedge clk);
    chk("R2 enable with A12 low", {31'b0, rom_en_n}, 32'd1);

    // R9: plain mode hides the bank but the register still loads
    @(posedge clk); #1; plain_mode = 1'b1;
    bus_seq(13'h0080, 8'h77, 5, 13'h0080, 8'h77, 0, 1'b0, "R9 plain write");
    @(posedge clk); #1; plain_mode = 1'b0;
    @(negedge clk);
    chk("R9 bank kept while plain", {24'b0, rom_addr[19:12]}, 32'h77);

    // R1: reset in the middle of operation
    do_reset();
    @(negedge clk);
    chk("R1 reset after use", {24'b0, rom_addr[19:12]}, 32'h00);
    bus_seq(13'h0080, 8'hA5, 4, 13'h0080, 8'hA5, 0, 1'b0, "R4 after reset");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule